// File: doc/BRIEF.md
# Byte-Serial Bitwise-AND Executor

This block takes an encoded 64-bit-mode AND instruction one byte per cycle through a valid/ready handshake. It accepts an optional operand-size prefix (0x66) and an optional REX byte (0x40 to 0x4F), then the opcode. Next come a ModRM byte where the form needs one, and then an immediate of one, two or four bytes. Once the last byte is in, the block spends one cycle on writeback. In that cycle it ANDs the selected operands from a sixteen-entry, 64-bit register file, writes the merged destination register and updates the status flags. It also reports the written register on a writeback port.

Only register-direct operands are handled. Any other encoding raises a one-cycle illegal-instruction pulse, drops the bytes taken so far and returns the parser to prefix wait. The surrounding core fills architectural registers through a separate load port. This is the only way non-zero values can enter the file, because an AND can never set a bit.

Top module: `and_exec`

## Requirements
- R1: After reset every register reads zero, `flags` is zero, `in_ready` is high, and `wb_valid` and `illegal` are low.
- R2: `in_ready` stays high while bytes are being collected. It goes low for exactly one cycle after the last byte of a legal instruction is accepted. `wb_valid` is high in the next cycle, with `wb_idx` set to the destination register and `wb_data` set to that register's full new 64-bit value.
- R3: Opcode 0x24 ANDs register 0 bits 7:0 with an 8-bit immediate. Opcode 0x25 ANDs register 0 with a 32-bit immediate by default. With the 0x66 prefix it uses a 16-bit immediate on bits 15:0. With REX.W it uses the 32-bit immediate sign-extended to 64 bits.
- R4: Opcodes 0x80, 0x81 and 0x83 take a ModRM byte and write the r/m operand. 0x80 takes imm8 at byte width. 0x81 takes imm16 under 0x66, otherwise imm32. 0x83 takes imm8 sign-extended to the operand width.
- R5: Opcodes 0x20 and 0x21 write the r/m register and read the reg register. Opcodes 0x22 and 0x23 write the reg register and read the r/m register. Even opcodes work on bytes, odd ones at full operand size.
- R6: The default operand size is 32 bits, and a 32-bit result zero-fills bits 63:32. REX bit 3 (W) selects 64 bits. 8-bit and 16-bit results leave all other register bits unchanged.
- R7: REX bit 2 supplies bit 3 of the ModRM reg register number. REX bit 0 supplies bit 3 of the r/m register number.
- R8: At byte width, register codes 4 to 7 select bits 15:8 of registers 0 to 3 when no REX byte is present. With any REX byte they select bits 7:0 of registers 4 to 7.
- R9: `flags` bit 0 (carry) and bit 4 (overflow) are cleared. Bit 1 is set when the low result byte has an even number of ones. Bit 2 is set when the result is zero. Bit 3 is the result's top bit at the operand width.
- R10: A ModRM mod field other than 3, a reg field other than 4 under 0x80/0x81/0x83, or an opcode outside 0x20 to 0x25 and 0x80/0x81/0x83 pulses `illegal` for one cycle in the cycle after the offending byte. That instruction causes no writeback, and the next byte is treated as the start of a new instruction.
- R11: Immediate bytes arrive least significant first.
- R12: `ld_en` writes `ld_data` in full into register `ld_idx`. Loads are issued while no instruction is in writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register number to load |
| ld_data | input | 64 | Value to load |
| illegal | output | 1 | One-cycle pulse: unsupported encoding discarded |
| wb_valid | output | 1 | One-cycle pulse: a register was written |
| wb_idx | output | 4 | Register number written |
| wb_data | output | 64 | Full new value of the written register |
| flags | output | 5 | {OF, SF, ZF, PF, CF} |

## Verification
The executor is driven with every opcode form: the accumulator short forms, the immediate group and both directions of the register-register forms. Each form is repeated with no prefix, with the size prefix and with REX.W. This exposes width selection, immediate length and whether the upper bits are zero-filled or preserved. Immediates with the top bit set show sign extension, and multi-byte immediates with distinct bytes show byte order. Byte operations on codes 4 to 7, with and without a REX byte, distinguish the high-byte mapping from the low-byte mapping. Encodings with REX.R and REX.B reach registers 8 and up. Each illegal encoding is followed by a read-back through an all-ones AND, which shows the register was left alone and the parser recovered.

// File: rtl/andx_pkg.sv
package andx_pkg;
  localparam int XLEN  = 64;
  localparam int NREG  = 16;
  localparam int RIDX  = $clog2(NREG);
  localparam int IMMB  = 4;
  localparam int IMMW  = IMMB * 8;
  localparam int CNTW  = $clog2(IMMB);
  localparam int NFLAG = 5;
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_ZF = 2;
  localparam int FL_SF = 3;
  localparam int FL_OF = 4;

  typedef enum logic [1:0] {SZ8, SZ16, SZ32, SZ64} opsz_t;
  typedef enum logic [1:0] {ST_PFX, ST_MODRM, ST_IMM, ST_EXEC} pst_t;

  typedef struct packed {
    logic [RIDX-1:0] idx;
    logic            hi;
  } opnd_t;

  typedef struct packed {
    opnd_t           dst;
    opnd_t           src;
    logic            src_imm;
    opsz_t           sz;
    logic [XLEN-1:0] imm;
  } uop_t;

  function automatic logic opc_legal(logic [7:0] opc);
    return ((opc[7:3] == 5'b00100) && (opc[2:0] <= 3'd5)) ||
           (opc == 8'h80) || (opc == 8'h81) || (opc == 8'h83);
  endfunction

  function automatic opsz_t size_of(logic [7:0] opc, logic w, logic osz);
    if (!opc[0]) return SZ8;
    if (w)       return SZ64;
    if (osz)     return SZ16;
    return SZ32;
  endfunction

  function automatic logic [CNTW:0] imm_len(logic [7:0] opc, opsz_t sz);
    if ((opc == 8'h25) || (opc == 8'h81))
      return (sz == SZ16) ? (CNTW+1)'(2) : (CNTW+1)'(4);
    return (CNTW+1)'(1);
  endfunction

  function automatic opnd_t map_reg(logic ext, logic [2:0] f, opsz_t sz, logic rex);
    opnd_t o;
    if ((sz == SZ8) && !rex && f[2]) begin
      o.idx = RIDX'(f[1:0]);
      o.hi  = 1'b1;
    end else begin
      o.idx = RIDX'({ext, f});
      o.hi  = 1'b0;
    end
    return o;
  endfunction
endpackage

// File: rtl/andx_decode.sv
module andx_decode
  import andx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       illegal,
  output logic       exec,
  output uop_t       uop
);
  pst_t            st_q, st_n;
  logic            osz_q, osz_n;
  logic            rex_q, rex_n;
  logic [3:0]      rexb_q, rexb_n;
  logic [7:0]      opc_q, opc_n;
  opnd_t           dst_q, dst_n, src_q, src_n;
  logic            simm_q, simm_n;
  logic [IMMW-1:0] imm_q, imm_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            ill_n;
  logic            ill_q;

  logic            acc;
  opsz_t           cur_sz;
  logic [CNTW:0]   len;
  opnd_t           reg_op, rm_op;
  logic            grp;
  logic [XLEN-1:0] imm_ext;

  assign in_ready = (st_q != ST_EXEC);
  assign acc      = in_valid && in_ready;
  assign cur_sz   = size_of(opc_q, rexb_q[3], osz_q);
  assign len      = imm_len(opc_q, cur_sz);
  assign reg_op   = map_reg(rexb_q[2], in_byte[5:3], cur_sz, rex_q);
  assign rm_op    = map_reg(rexb_q[0], in_byte[2:0], cur_sz, rex_q);
  assign grp      = opc_q[7];

  always_comb begin
    st_n   = st_q;
    osz_n  = osz_q;
    rex_n  = rex_q;
    rexb_n = rexb_q;
    opc_n  = opc_q;
    dst_n  = dst_q;
    src_n  = src_q;
    simm_n = simm_q;
    imm_n  = imm_q;
    cnt_n  = cnt_q;
    ill_n  = 1'b0;
    unique case (st_q)
      ST_PFX: if (acc) begin
        if (in_byte == 8'h66) begin
          osz_n = 1'b1;
        end else if (in_byte[7:4] == 4'h4) begin
          rex_n  = 1'b1;
          rexb_n = in_byte[3:0];
        end else if (opc_legal(in_byte)) begin
          opc_n = in_byte;
          cnt_n = '0;
          imm_n = '0;
          if (in_byte[7:1] == 7'h12) begin
            dst_n  = '{idx: '0, hi: 1'b0};
            simm_n = 1'b1;
            st_n   = ST_IMM;
          end else begin
            st_n = ST_MODRM;
          end
        end else begin
          ill_n  = 1'b1;
          osz_n  = 1'b0;
          rex_n  = 1'b0;
          rexb_n = '0;
        end
      end
      ST_MODRM: if (acc) begin
        if ((in_byte[7:6] != 2'b11) || (grp && (in_byte[5:3] != 3'd4))) begin
          ill_n  = 1'b1;
          osz_n  = 1'b0;
          rex_n  = 1'b0;
          rexb_n = '0;
          st_n   = ST_PFX;
        end else if (grp) begin
          dst_n  = rm_op;
          simm_n = 1'b1;
          st_n   = ST_IMM;
        end else begin
          simm_n = 1'b0;
          if (!opc_q[1]) begin
            dst_n = rm_op;
            src_n = reg_op;
          end else begin
            dst_n = reg_op;
            src_n = rm_op;
          end
          st_n = ST_EXEC;
        end
      end
      ST_IMM: if (acc) begin
        imm_n[{cnt_q, 3'b000} +: 8] = in_byte;
        cnt_n = cnt_q + 1'b1;
        if (({1'b0, cnt_q} + 1'b1) == len) st_n = ST_EXEC;
      end
      ST_EXEC: begin
        st_n   = ST_PFX;
        osz_n  = 1'b0;
        rex_n  = 1'b0;
        rexb_n = '0;
      end
      default: st_n = ST_PFX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PFX;
      osz_q  <= 1'b0;
      rex_q  <= 1'b0;
      rexb_q <= '0;
      opc_q  <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      simm_q <= 1'b0;
      imm_q  <= '0;
      cnt_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      ill_q <= ill_n;
      if (acc || (st_q == ST_EXEC)) begin
        st_q   <= st_n;
        osz_q  <= osz_n;
        rex_q  <= rex_n;
        rexb_q <= rexb_n;
        opc_q  <= opc_n;
        dst_q  <= dst_n;
        src_q  <= src_n;
        simm_q <= simm_n;
        imm_q  <= imm_n;
        cnt_q  <= cnt_n;
      end
    end
  end

  always_comb begin
    unique case (len)
      (CNTW+1)'(1): imm_ext = {{(XLEN-8){imm_q[7]}}, imm_q[7:0]};
      (CNTW+1)'(2): imm_ext = {{(XLEN-16){imm_q[15]}}, imm_q[15:0]};
      default:      imm_ext = {{(XLEN-IMMW){imm_q[IMMW-1]}}, imm_q};
    endcase
  end

  assign illegal     = ill_q;
  assign exec        = (st_q == ST_EXEC);
  assign uop.dst     = dst_q;
  assign uop.src     = src_q;
  assign uop.src_imm = simm_q;
  assign uop.sz      = cur_sz;
  assign uop.imm     = imm_ext;
endmodule

// File: rtl/andx_rf.sv
module andx_rf
  import andx_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] rf_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit_wb, hit_ld;
    assign hit_wb = we && (widx == AW'(g));
    assign hit_ld = ld_en && (ld_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rf_q[g] <= '0;
      else if (hit_wb) rf_q[g] <= wdata;
      else if (hit_ld) rf_q[g] <= ld_data;
    end
  end

  assign rdata_a = rf_q[raddr_a];
  assign rdata_b = rf_q[raddr_b];
endmodule

// File: rtl/andx_alu.sv
module andx_alu
  import andx_pkg::*;
(
  input  uop_t             uop,
  input  logic [XLEN-1:0]  dst_full,
  input  logic [XLEN-1:0]  src_full,
  output logic [XLEN-1:0]  merged,
  output logic [NFLAG-1:0] fl
);
  logic [XLEN-1:0] a, b, mask, res;
  logic            msb;

  always_comb begin
    a = uop.dst.hi ? (dst_full >> 8) : dst_full;
    if (uop.src_imm) b = uop.imm;
    else             b = uop.src.hi ? (src_full >> 8) : src_full;
    unique case (uop.sz)
      SZ8:     mask = XLEN'({8{1'b1}});
      SZ16:    mask = XLEN'({16{1'b1}});
      SZ32:    mask = XLEN'({32{1'b1}});
      default: mask = '1;
    endcase
    res = a & b & mask;
    unique case (uop.sz)
      SZ8:     msb = res[7];
      SZ16:    msb = res[15];
      SZ32:    msb = res[31];
      default: msb = res[XLEN-1];
    endcase
    unique case (uop.sz)
      SZ8:     merged = uop.dst.hi ? {dst_full[XLEN-1:16], res[7:0], dst_full[7:0]}
                                   : {dst_full[XLEN-1:8], res[7:0]};
      SZ16:    merged = {dst_full[XLEN-1:16], res[15:0]};
      SZ32:    merged = {{(XLEN-32){1'b0}}, res[31:0]};
      default: merged = res;
    endcase
    fl        = '0;
    fl[FL_PF] = ~^res[7:0];
    fl[FL_ZF] = (res == '0);
    fl[FL_SF] = msb;
  end
endmodule

// File: rtl/and_exec.sv
module and_exec
  import andx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             ld_en,
  input  logic [RIDX-1:0]  ld_idx,
  input  logic [XLEN-1:0]  ld_data,
  output logic             illegal,
  output logic             wb_valid,
  output logic [RIDX-1:0]  wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic [NFLAG-1:0] flags
);
  uop_t             uop;
  logic             exec;
  logic [XLEN-1:0]  dst_full, src_full, merged;
  logic [NFLAG-1:0] fl_n;

  andx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .illegal(illegal), .exec(exec), .uop(uop)
  );

  andx_rf #(.N(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(exec), .widx(uop.dst.idx), .wdata(merged),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .raddr_a(uop.dst.idx), .raddr_b(uop.src.idx),
    .rdata_a(dst_full), .rdata_b(src_full)
  );

  andx_alu u_alu (
    .uop(uop), .dst_full(dst_full), .src_full(src_full),
    .merged(merged), .fl(fl_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      flags    <= '0;
    end else begin
      wb_valid <= exec;
      if (exec) begin
        wb_idx  <= uop.dst.idx;
        wb_data <= merged;
        flags   <= fl_n;
      end
    end
  end
endmodule

// File: rtl/and_exec_chk.sv
module and_exec_chk
  import andx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             illegal,
  input logic             wb_valid,
  input logic [NFLAG-1:0] flags
);
  // R2
  ready_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R2
  stall_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> wb_valid);
  // R2
  wb_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(!in_ready));
  // R9
  cf_of_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!flags[FL_CF] && !flags[FL_OF]));
  // R10
  ill_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, wb_valid}));
  // R10
  ill_parser_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> in_ready);
endmodule

bind and_exec and_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .illegal(illegal),
  .wb_valid(wb_valid), .flags(flags)
);

// File: tb/test_and_exec.sv
module test_and_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [63:0] ld_data = '0;
  logic        illegal, wb_valid;
  logic [3:0]  wb_idx;
  logic [63:0] wb_data;
  logic [4:0]  flags;

  always #5 clk = ~clk;

  and_exec i_and_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .illegal(illegal), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .flags(flags)
  );

  typedef struct packed {
    logic        ill;
    logic [3:0]  idx;
    logic [63:0] val;
    logic [4:0]  fl;
  } item_t;

  item_t       exp_q[$];
  string       tag_q[$];
  logic [7:0]  pend[$];
  logic [63:0] mdl [16];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] rd(input int idx, input bit hi, input int w);
    logic [63:0] v = hi ? (mdl[idx] >> 8) : mdl[idx];
    return v & wmask(w);
  endfunction

  // model update, expectation push, then byte stream
  task automatic op(input int idx, input bit hi, input int w, input logic [63:0] src, input string tag);
    logic [63:0] res, nv;
    logic [4:0]  f;
    int ones = 0;
    item_t it;
    res = rd(idx, hi, w) & src & wmask(w);
    for (int i = 0; i < 8; i++) ones += int'(res[i]);
    f = '0;
    f[1] = (ones % 2 == 0);
    f[2] = (res == 0);
    f[3] = res[w-1];
    nv = mdl[idx];
    if (w == 8 && hi) nv[15:8] = res[7:0];
    else if (w == 8)  nv[7:0]  = res[7:0];
    else if (w == 16) nv[15:0] = res[15:0];
    else if (w == 32) nv = {32'h0, res[31:0]};
    else              nv = res;
    mdl[idx] = nv;
    it = '{ill: 1'b0, idx: 4'(idx), val: nv, fl: f};
    exp_q.push_back(it);
    tag_q.push_back(tag);
    send(1'b1);
  endtask

  task automatic bad_op(input string tag);
    exp_q.push_back('{ill: 1'b1, idx: '0, val: '0, fl: '0});
    tag_q.push_back(tag);
    send(1'b0);
  endtask

  task automatic send(input bit legal);
    foreach (pend[i]) begin
      @(negedge clk);
      chk(in_ready === 1'b1, "R2 ready while collecting", 64'(in_ready), 64'd1);
      in_valid = 1'b1;
      in_byte  = pend[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (legal) chk(in_ready === 1'b0, "R2 ready drop", 64'(in_ready), 64'd0);
    @(negedge clk);
  endtask

  task automatic load(input int idx, input logic [63:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[idx] = v;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && (wb_valid || illegal)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected event", 64'({illegal, wb_valid}), 64'd0);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(illegal == e.ill && wb_valid == !e.ill, {t, " event kind"}, 64'(illegal), 64'(e.ill));
        if (!e.ill) begin
          chk(wb_idx == e.idx, {t, " wb_idx"}, 64'(wb_idx), 64'(e.idx));
          chk(wb_data == e.val, {t, " wb_data"}, wb_data, e.val);
          chk(flags == e.fl, {t, " R9 flags"}, 64'(flags), 64'(e.fl));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    chk(flags === 5'd0, "R1 flags", 64'(flags), 64'd0);
    chk(wb_valid === 1'b0 && illegal === 1'b0, "R1 outputs idle", 64'({wb_valid, illegal}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: register reads zero after reset
    pend = '{8'h48, 8'h83, 8'hE3, 8'hFF}; op(3, 0, 64, '1, "R1");

    load(0, 64'hFEDC_BA98_7654_3210);
    load(1, 64'h0F0F_F0F0_A5A5_C3C3);
    load(2, 64'h8000_0000_FFFF_00FF);
    load(3, 64'h1234_5678_9ABC_DEF0);
    load(4, 64'h0000_0000_0000_00AA);
    load(9, 64'hF0F0_F0F0_8F0F_0F0F);
    pend = '{8'h48, 8'h83, 8'hE1, 8'hFF}; op(1, 0, 64, '1, "R12");

    pend = '{8'h24, 8'h0F}; op(0, 0, 8, 64'h0F, "R3");
    pend = '{8'h25, 8'h78, 8'h56, 8'h34, 8'h92}; op(0, 0, 32, 64'h9234_5678, "R11");
    load(0, 64'hFEDC_BA98_7654_3210);
    pend = '{8'h66, 8'h25, 8'hF0, 8'hFF}; op(0, 0, 16, 64'hFFF0, "R3");
    pend = '{8'h48, 8'h25, 8'h00, 8'h00, 8'h00, 8'h80}; op(0, 0, 64, 64'hFFFF_FFFF_8000_0000, "R3");
    load(0, 64'hFEDC_BA98_7654_3210);

    pend = '{8'h80, 8'hE1, 8'h3C}; op(1, 0, 8, 64'h3C, "R4");
    pend = '{8'h83, 8'hE3, 8'hF0}; op(3, 0, 32, 64'hFFFF_FFF0, "R4");
    pend = '{8'h66, 8'h83, 8'hE2, 8'h80}; op(2, 0, 16, 64'hFF80, "R4");
    pend = '{8'h66, 8'h81, 8'hE2, 8'h34, 8'hF2}; op(2, 0, 16, 64'hF234, "R4");
    pend = '{8'h48, 8'h81, 8'hE1, 8'h00, 8'hFF, 8'hFF, 8'hFF}; op(1, 0, 64, 64'hFFFF_FFFF_FFFF_FF00, "R6");

    load(1, 64'h0F0F_F0F0_A5A5_C3C3);
    pend = '{8'h21, 8'hC8}; op(0, 0, 32, rd(1, 0, 32), "R5");
    pend = '{8'h23, 8'hC8}; op(1, 0, 32, rd(0, 0, 32), "R5");
    load(3, 64'h1234_5678_9ABC_DEF0);
    load(2, 64'hFF00_FF00_FFFF_00FF);
    pend = '{8'h48, 8'h21, 8'hD3}; op(3, 0, 64, rd(2, 0, 64), "R6");
    pend = '{8'h66, 8'h21, 8'hD3}; op(3, 0, 16, rd(2, 0, 16), "R6");

    load(0, 64'hFEDC_BA98_7654_3210);
    pend = '{8'h4C, 8'h21, 8'hC8}; op(0, 0, 64, rd(9, 0, 64), "R7");
    load(0, 64'hFEDC_BA98_F654_3210);
    pend = '{8'h41, 8'h23, 8'hC1}; op(0, 0, 32, rd(9, 0, 32), "R7");

    load(0, 64'hFEDC_BA98_7654_F3F6);
    load(3, 64'h1234_5678_9ABC_DEF0);
    pend = '{8'h20, 8'hE0}; op(0, 0, 8, rd(0, 1, 8), "R8");
    pend = '{8'h40, 8'h20, 8'hE0}; op(0, 0, 8, rd(4, 0, 8), "R8");
    pend = '{8'h22, 8'hFC}; op(3, 1, 8, rd(0, 1, 8), "R8");

    load(0, 64'h0000_0000_0000_0080);
    pend = '{8'h24, 8'hFF}; op(0, 0, 8, 64'hFF, "R9");
    load(5, 64'h8000_0000_0000_0003);
    pend = '{8'h48, 8'h83, 8'hE5, 8'hFF}; op(5, 0, 64, '1, "R9");

    load(0, 64'hFEDC_BA98_7654_3210);
    pend = '{8'h21, 8'h08}; bad_op("R10 mod");
    pend = '{8'h80, 8'hC8}; bad_op("R10 group reg");
    pend = '{8'h48, 8'h0F}; bad_op("R10 opcode");
    pend = '{8'h48, 8'h83, 8'hE0, 8'hFF}; op(0, 0, 64, '1, "R10");
    pend = '{8'h48, 8'h83, 8'hE1, 8'hFF}; op(1, 0, 64, '1, "R10");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all results seen", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule